// File: doc/BRIEF.md
# Dual-Mode Multiplexed Register Port

This block is the host-facing register port of a line framer. A host processor reaches it over one 8-bit bus that carries first an address and then data, plus a chip select and three control pins. A static strap input picks how the three control pins are read. With the strap low they behave as an active-low read pulse, an address-latch pulse and an active-low write pulse (Intel style). With the strap high they behave as an active-low data strobe, an address strobe and a read/not-write level (Motorola style).

All host pins are sampled into the block's clock domain. A rising edge on the address pin loads the latched address from the bus. Data accesses then read from or write to a bank of 8-bit registers. The low part of the address space holds writable control registers, whose contents go out to the framer in parallel. The next part is a read-only window onto status bytes that the framer supplies. Every address above that window reads as zero. The block asks for the bus, through an output enable, only while a valid read is in progress. The pad ring builds the tri-state driver from `bus_oe` and `bus_out`.

Top module: `mpb_host_port`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `bus_oe` is 0, every control register holds 0 (so `cfg_out` is 0), and the latched address is 0.
- R2: A rising edge on `pin_ale_as` loads the bus value into the latched address in both bus styles, whatever the level of `cs_n`.
- R3: The latched address keeps its value until the next rising edge on `pin_ale_as`, so several data accesses can use one address phase.
- R4: In Intel style (`bus_style`=0), while `cs_n`=0 and `pin_rd_ds`=0, `bus_oe` is 1 and `bus_out` carries the content of the latched address. Both follow the pins after one clock of sampling delay.
- R5: In Intel style, a rising edge on `pin_wr_rw` while `cs_n`=0 writes the bus value present just before that edge into the addressed control register.
- R6: In Motorola style (`bus_style`=1), while `cs_n`=0, `pin_rd_ds`=0 and `pin_wr_rw`=1, `bus_oe` is 1 and `bus_out` carries the content of the latched address.
- R7: In Motorola style, a rising edge on `pin_rd_ds` writes the bus value into the addressed control register when `pin_wr_rw`=0 and `cs_n`=0 held just before that edge.
- R8: With `cs_n`=1, no strobe sequence changes any register and `bus_oe` stays 0.
- R9: Addresses NUM_CTRL to NUM_CTRL+NUM_STAT-1 (16 to 19 by default) are read-only. A read returns status byte (address-NUM_CTRL), taken from bits [8k+7:8k] of `stat_in`, and writes there change nothing.
- R10: Addresses from NUM_CTRL+NUM_STAT up to 255 read as zero, and writes to them change nothing.
- R11: `bus_oe` is 1 under no other condition than those in R4 and R6. In particular it stays 0 during a write in either style. While `bus_oe` is 0, `bus_out` is 0.
- R12: Control register k appears on `cfg_out` bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_style | input | 1 | Strap: 0 Intel style, 1 Motorola style |
| cs_n | input | 1 | Active-low chip select |
| pin_rd_ds | input | 1 | Read pulse (Intel) or data strobe (Motorola), active low |
| pin_ale_as | input | 1 | Address latch / address strobe; its rising edge captures the address |
| pin_wr_rw | input | 1 | Write pulse, active low (Intel) or read/not-write level (Motorola) |
| bus_in | input | 8 | Shared address/data bus as seen at the pad |
| bus_out | output | 8 | Read data to drive onto the bus |
| bus_oe | output | 1 | Drive enable for the bus pad |
| stat_in | input | 32 | Status bytes from the framer, byte k at bits [8k+7:8k] |
| cfg_out | output | 128 | Control register contents, register k at bits [8k+7:8k] |

## Verification
The hardest cases to reach are the ones that look like valid accesses but must have no effect. These are a complete write strobe with chip select high, a write into the status window, and a write above it. Each can only be seen through a later read or through `cfg_out`. The bench sweeps every address from 0 to 23, plus the top addresses, in both bus styles. At each address it writes a value computed from the address and the style, reads it back, and then rereads the whole range, so any stray write shows up as a mismatch against the arithmetic model. Reads also come after a single address phase to prove the address is held, and `bus_oe` is probed in the middle of every write strobe.

// File: rtl/mpb_pkg.sv
// Shared types for the multiplexed host register port.
// Assumes: one 8-bit shared bus, three control pins plus chip select.
package mpb_pkg;

    typedef enum logic {
        STYLE_INTEL = 1'b0,
        STYLE_MOTO  = 1'b1
    } bus_style_e;

    // One sample of the host control pins.
    typedef struct packed {
        logic cs_n;
        logic pa;   // read pulse / data strobe
        logic pb;   // address latch / address strobe
        logic pc;   // write pulse / read-not-write
    } pin_smp_t;

    localparam pin_smp_t PIN_IDLE = '{cs_n: 1'b1, pa: 1'b1, pb: 1'b0, pc: 1'b1};

endpackage

// File: rtl/mpb_pin_sampler.sv
// Samples the asynchronous host pins and bus into the clock domain.
// Keeps a current sample and the one before it for edge detection.
// Assumes: host holds each pin level for at least two clocks.
module mpb_pin_sampler
    import mpb_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pin_smp_t         pins,
    input  logic [BUS_W-1:0] bus_in,
    output pin_smp_t         cur,
    output pin_smp_t         prev,
    output logic [BUS_W-1:0] bus_cur,
    output logic [BUS_W-1:0] bus_prev
);

    // Two-deep sample pipeline of pins and bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= PIN_IDLE;
            prev     <= PIN_IDLE;
            bus_cur  <= '0;
            bus_prev <= '0;
        end else begin
            cur      <= pins;
            prev     <= cur;
            bus_cur  <= bus_in;
            bus_prev <= bus_cur;
        end
    end

endmodule

// File: rtl/mpb_access_decode.sv
// Turns sampled pins into address-strobe, read-active and write-fire
// events according to the bus style strap.
// Assumes: bus_style is static while accesses are in progress.
module mpb_access_decode
    import mpb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bus_style,
    input  logic     cs_n,
    input  pin_smp_t cur,
    input  pin_smp_t prev,
    output logic     addr_stb,
    output logic     rd_act,
    output logic     wr_fire
);

    logic intel_rd, intel_wr, moto_rd, moto_wr;

    // Event decode for both styles, then selected by the strap.
    always_comb begin
        addr_stb = cur.pb && !prev.pb;
        intel_rd = !cur.cs_n && !cur.pa;
        intel_wr = !prev.cs_n && !prev.pc && cur.pc;
        moto_rd  = !cur.cs_n && !cur.pa && cur.pc;
        moto_wr  = !prev.cs_n && !prev.pa && cur.pa && !prev.pc;
        if (bus_style == STYLE_MOTO) begin
            rd_act  = moto_rd;
            wr_fire = moto_wr;
        end else begin
            rd_act  = intel_rd;
            wr_fire = intel_wr;
        end
    end

    AST_WRITE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !$past(cs_n, 2)); // R8

    AST_MOTO_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_style && wr_fire) |-> !rd_act); // R11

endmodule

// File: rtl/mpb_reg_bank.sv
// Control registers (writable) followed by a read-only status window;
// everything above reads zero.
// Assumes: addr is stable while wr_en is high.
module mpb_reg_bank #(
    parameter int BUS_W    = 8,
    parameter int NUM_CTRL = 16,
    parameter int NUM_STAT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUS_W-1:0]          addr,
    input  logic                      wr_en,
    input  logic [BUS_W-1:0]          wr_data,
    input  logic [NUM_STAT*BUS_W-1:0] stat_in,
    output logic [BUS_W-1:0]          rd_data,
    output logic [NUM_CTRL*BUS_W-1:0] cfg_q
);

    localparam int STAT_LO = NUM_CTRL;
    localparam int STAT_HI = NUM_CTRL + NUM_STAT;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
            // Control register gi: loads on a write addressed to it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[gi*BUS_W +: BUS_W] <= '0;
                else if (wr_en && (int'(addr) == gi))
                    cfg_q[gi*BUS_W +: BUS_W] <= wr_data;
            end
        end
    endgenerate

    // Read multiplexer across control, status and empty space.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CTRL; k++)
            if (int'(addr) == k) rd_data = cfg_q[k*BUS_W +: BUS_W];
        for (int k = 0; k < NUM_STAT; k++)
            if (int'(addr) == STAT_LO + k) rd_data = stat_in[k*BUS_W +: BUS_W];
    end

    AST_RO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= STAT_LO) |=> $stable(cfg_q)); // R9

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= STAT_HI) |-> (rd_data == '0)); // R10

endmodule

// File: rtl/mpb_host_port.sv
// Host register port with a multiplexed address/data bus and strap-selected
// Intel or Motorola control semantics. Drives the bus only during reads.
// Assumes: host pins are slow relative to clk (held >= 2 clocks).
module mpb_host_port
    import mpb_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int NUM_CTRL = 16,
    parameter int NUM_STAT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_style,
    input  logic                      cs_n,
    input  logic                      pin_rd_ds,
    input  logic                      pin_ale_as,
    input  logic                      pin_wr_rw,
    input  logic [BUS_W-1:0]          bus_in,
    output logic [BUS_W-1:0]          bus_out,
    output logic                      bus_oe,
    input  logic [NUM_STAT*BUS_W-1:0] stat_in,
    output logic [NUM_CTRL*BUS_W-1:0] cfg_out
);

    pin_smp_t         pins, cur, prev;
    logic [BUS_W-1:0] bus_cur, bus_prev, addr_q, rd_data;
    logic             addr_stb, rd_act, wr_fire;

    assign pins = '{cs_n: cs_n, pa: pin_rd_ds, pb: pin_ale_as, pc: pin_wr_rw};

    mpb_pin_sampler #(.BUS_W(BUS_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .pins(pins), .bus_in(bus_in),
        .cur(cur), .prev(prev), .bus_cur(bus_cur), .bus_prev(bus_prev)
    );

    mpb_access_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
        .cur(cur), .prev(prev),
        .addr_stb(addr_stb), .rd_act(rd_act), .wr_fire(wr_fire)
    );

    // Address latch: loads on the address-strobe edge, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (addr_stb) addr_q <= bus_cur;
    end

    mpb_reg_bank #(.BUS_W(BUS_W), .NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .wr_en(wr_fire),
        .wr_data(bus_prev), .stat_in(stat_in),
        .rd_data(rd_data), .cfg_q(cfg_out)
    );

    // Bus drive: enable and data only during a valid read.
    always_comb begin
        bus_oe  = rd_act;
        bus_out = rd_act ? rd_data : '0;
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(cs_n)); // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> $stable(addr_q)); // R3

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0)); // R11

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> !bus_oe); // R11

endmodule

// File: tb/mpb_host_port_tb.sv
// Sweeps all low addresses and the top of the map in both bus styles,
// comparing against an arithmetic model of the register map.
module mpb_host_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 16;
    localparam int NS = 4;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         bus_style = 0;
    logic         cs_n = 1, pin_rd_ds = 1, pin_ale_as = 0, pin_wr_rw = 1;
    logic [7:0]   bus_in = '0;
    logic [7:0]   bus_out;
    logic         bus_oe;
    logic [NS*8-1:0] stat_in;
    logic [NC*8-1:0] cfg_out;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] model [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpb_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
        .pin_rd_ds(pin_rd_ds), .pin_ale_as(pin_ale_as), .pin_wr_rw(pin_wr_rw),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .stat_in(stat_in), .cfg_out(cfg_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_rd(input int a);
        if (a < NC)           return model[a];
        else if (a < NC + NS) return 8'hA0 + 8'(a - NC);
        else                  return 8'h00;
    endfunction

    task automatic set_addr(input logic [7:0] a);
        bus_in = a; cyc(1);
        pin_ale_as = 1; cyc(2);
        pin_ale_as = 0; cyc(1);
    endtask

    task automatic do_write(input logic [7:0] d, input bit use_cs);
        if (bus_style == 1'b0) begin
            cs_n = !use_cs; bus_in = d; pin_wr_rw = 0; cyc(3);
            chk("R11 oe during intel write", 32'(bus_oe), 0);
            pin_wr_rw = 1; cyc(3);
            cs_n = 1; cyc(2);
        end else begin
            cs_n = !use_cs; bus_in = d; pin_wr_rw = 0; cyc(1);
            pin_rd_ds = 0; cyc(3);
            chk("R11 oe during moto write", 32'(bus_oe), 0);
            pin_rd_ds = 1; cyc(3);
            pin_wr_rw = 1; cs_n = 1; cyc(2);
        end
    endtask

    task automatic do_read(input logic [7:0] exp, input string req);
        bus_in = 8'h5A; cs_n = 0; pin_rd_ds = 0; cyc(3);
        chk(req, 32'(bus_oe), 1);
        chk(req, 32'(bus_out), 32'(exp));
        pin_rd_ds = 1; cs_n = 1; cyc(3);
        chk("R11 oe released", 32'(bus_oe), 0);
        chk("R11 out zero idle", 32'(bus_out), 0);
    endtask

    initial begin
        for (int k = 0; k < NS; k++) stat_in[k*8 +: 8] = 8'hA0 + 8'(k);
        for (int k = 0; k < NC; k++) model[k] = 8'h00;
        cyc(3);
        rst_n = 1; cyc(2);
        // R1 reset state
        chk("R1 oe", 32'(bus_oe), 0);
        chk("R1 cfg", 32'(cfg_out != '0), 0);
        do_read(8'h00, "R1 addr zero after reset");

        for (int m = 0; m < 2; m++) begin
            bus_style = m[0]; cyc(2);
            for (int a = 0; a < 26; a++) begin
                int addr = (a < 24) ? a : 230 + a;
                logic [7:0] d = 8'((addr * 37 + m * 91 + 5) & 255);
                set_addr(8'(addr));
                do_write(d, 1);
                if (addr < NC) model[addr] = d;
                // R4 R6 R5 R7 R9 R10: readback through held address (R3)
                do_read(expect_rd(addr), m ? "R6 R7 R9 R10 moto readback" : "R4 R5 R9 R10 intel readback");
                do_read(expect_rd(addr), "R3 second read same address");
                // R2 the latch ignores chip select (cs_n high in set_addr)
            end
            for (int a = 0; a < 24; a++) begin
                set_addr(8'(a));
                do_read(expect_rd(a), "R9 R10 sweep reread");
            end
            // R12 parallel register outputs
            for (int k = 0; k < NC; k++)
                chk("R12 cfg_out slice", 32'(cfg_out[k*8 +: 8]), 32'(model[k]));
            // R8 strobes with cs high: no write, no drive
            set_addr(8'd3);
            do_write(8'hEE, 0);
            chk("R8 cfg unchanged", 32'(cfg_out[3*8 +: 8]), 32'(model[3]));
            bus_in = 8'h00; pin_rd_ds = 0; cyc(3);
            chk("R8 no drive cs high", 32'(bus_oe), 0);
            pin_rd_ds = 1; cyc(2);
            do_read(model[3], "R8 readback");
        end

        // R11 Motorola: ds low with rw low does not drive
        bus_style = 1; cyc(2);
        cs_n = 0; pin_wr_rw = 0; cyc(1); pin_rd_ds = 0; cyc(3);
        chk("R11 moto rw low", 32'(bus_oe), 0);
        pin_wr_rw = 1; cyc(3);
        chk("R6 rw high drives", 32'(bus_oe), 1);
        pin_rd_ds = 1; cs_n = 1; cyc(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule